// File: doc/BRIEF.md
# External and Pin-Change Interrupt Unit

This block watches one dedicated interrupt pad and two groups of pin-change pads, and turns activity on them into interrupt requests for a small processor core. The dedicated pad has a selectable sense mode: low level, any change, falling edge or rising edge. Every pad passes through a two-flop synchronizer and one history register before detection. Edge and change events are held in sticky flags until the core acknowledges them or software clears them. Each group pad counts only when its bit in an external per-pin mask is set.

Software reaches three byte-wide locations on a simple register bus. One holds the sense mode, one holds the per-source enables and one holds the sticky flags, which are cleared by writing 1. A request reaches the core only when its source enable and the core's global interrupt enable are both set. When more than one source is pending, the block names a single winner: the dedicated pad first, then group 0, then group 1.

Top module: `ext_irq_unit`

## Requirements
- R1: After reset the sense mode is 00 (low level), all enables and flags are 0, and every request output is 0.
- R2: Address 0 holds the sense mode in bits 1:0, and bits 7:2 read as 0. Address 1 holds the enables: bit 6 for the dedicated pad, bit 5 for group 1 and bit 4 for group 0; bits 7 and 3:0 read as 0. Address 2 holds the sticky flags in the same bit positions.
- R3: The sense code works as follows. 01 flags any change of the synchronized dedicated pad, 10 flags a falling edge and 11 flags a rising edge. The flag is sticky.
- R4: With sense code 00 the dedicated request follows the synchronized pad. It is asserted while the pad is low and drops once the pad is high; nothing is latched.
- R5: A request output is 1 only when the source's enable bit and the global enable input are both 1.
- R6: A pad pulse that lasts two clock periods is caught in the edge and change modes.
- R7: A change on a group pad sets that group's flag only if the pad's mask bit is 1.
- R8: A flag clears on its acknowledge strobe or on a register write of 1 to its bit. An event in the same cycle as the clear keeps the flag set.
- R9: irq_valid is 1 when any request is asserted. irq_id then names the winner: 0 for the dedicated pad, 1 for group 0, 2 for group 1, in that priority order.
- R10: A write to the sense-mode register clears the dedicated flag, and the new mode applies from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register address (0 mode, 1 enables, 2 flags) |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| gie | input | 1 | Global interrupt enable from the core |
| ext_pad | input | 1 | Dedicated interrupt pad value |
| pc_pad | input | 2*PC_PINS | Group pads; group g uses bits [g*PC_PINS +: PC_PINS] |
| pc_mask | input | 2*PC_PINS | Per-pad mask, laid out the same way as pc_pad |
| ext_ack | input | 1 | Acknowledge for the dedicated flag |
| pc_ack | input | 2 | Acknowledge for each group flag |
| ext_req | output | 1 | Dedicated source request |
| pc_req | output | 2 | Group requests |
| irq_valid | output | 1 | Any request asserted |
| irq_id | output | 2 | Winning source |

## Verification
The bench sweeps every sense code against both pad transitions. A decoder with the falling and rising codes swapped, or with a change mode that only sees one direction, would raise a flag where none belongs or miss one. Low-level mode is checked both ways: the request must drop once the pad goes high, which catches a design that latches the level. Every group pad is toggled with its mask bit set and cleared, and an acknowledge is timed into the same cycle as a fresh event, where a design whose clear beat its set would lose the event. Simultaneous pending sources show whether the dedicated pad wins the priority, and mode writes show whether a stale flag outlives a mode change.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_EN   = 2'd1;
  localparam logic [1:0] ADDR_FLAG = 2'd2;
  localparam int BIT_EXT = 6;
  localparam int BIT_G1  = 5;
  localparam int BIT_G0  = 4;

  // edge decision from the previous and current synchronized samples
  function automatic logic edge_hit(sense_e m, logic prev, logic cur);
    case (m)
      SENSE_ANY:  return prev ^ cur;
      SENSE_FALL: return prev & ~cur;
      SENSE_RISE: return ~prev & cur;
      default:    return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/irq_sampler.sv
module irq_sampler #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pad,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev,
  output logic         hist_ok
);
  logic [W-1:0] meta_q;
  logic [1:0]   fill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur    <= '0;
      prev   <= '0;
      fill_q <= '0;
    end else begin
      meta_q <= pad;
      cur    <= meta_q;
      prev   <= cur;
      if (fill_q != 2'd3) fill_q <= fill_q + 2'd1;
    end
  end

  // history holds real pad samples only once the pipeline has filled
  assign hist_ok = (fill_q == 2'd3);
endmodule

// File: rtl/ext_sense.sv
module ext_sense
  import ext_irq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  sense_e mode,
  input  logic   cur,
  input  logic   prev,
  input  logic   hist_ok,
  input  logic   ack,
  input  logic   w1c,
  input  logic   mode_wr,
  output logic   evt,
  output logic   flag,
  output logic   pend
);
  assign evt = hist_ok & edge_hit(mode, prev, cur);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (mode_wr) flag <= 1'b0;
    else if (evt)     flag <= 1'b1;
    else if (ack | w1c) flag <= 1'b0;
  end

  assign pend = (mode == SENSE_LOW) ? (hist_ok & ~cur) : flag;

  a_r3_evt_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !mode_wr) |=> flag);
  a_r4_level_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SENSE_LOW && cur) |-> !pend);
  a_r10_mode_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> !flag);
endmodule

// File: rtl/pc_detect.sv
module pc_detect #(
  parameter int PINS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] cur,
  input  logic [PINS-1:0] prev,
  input  logic [PINS-1:0] mask,
  input  logic            hist_ok,
  input  logic            ack,
  input  logic            w1c,
  output logic            evt,
  output logic            flag
);
  logic [PINS-1:0] diff;
  assign diff = (cur ^ prev) & mask;
  assign evt  = hist_ok & (|diff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag <= 1'b0;
    else if (evt)       flag <= 1'b1;
    else if (ack | w1c) flag <= 1'b0;
  end

  a_r7_evt_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag);
  a_r8_clear_wins_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !evt) |=> !flag);
endmodule

// File: rtl/ext_irq_unit.sv
module ext_irq_unit
  import ext_irq_pkg::*;
#(
  parameter int PC_PINS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           reg_addr,
  input  logic                 reg_we,
  input  logic [7:0]           reg_wdata,
  output logic [7:0]           reg_rdata,
  input  logic                 gie,
  input  logic                 ext_pad,
  input  logic [2*PC_PINS-1:0] pc_pad,
  input  logic [2*PC_PINS-1:0] pc_mask,
  input  logic                 ext_ack,
  input  logic [1:0]           pc_ack,
  output logic                 ext_req,
  output logic [1:0]           pc_req,
  output logic                 irq_valid,
  output logic [1:0]           irq_id
);
  localparam int NGRP = 2;
  localparam int NPAD = NGRP * PC_PINS + 1;

  sense_e           mode_q;
  logic             en_ext_q;
  logic [NGRP-1:0]  en_grp_q;
  logic             mode_wr, flag_wr;
  logic [NPAD-1:0]  s_cur, s_prev;
  logic             hist_ok;
  logic             ext_evt, ext_flag, ext_pend;
  logic [NGRP-1:0]  grp_evt, grp_flag;

  assign mode_wr = reg_we && reg_addr == ADDR_MODE;
  assign flag_wr = reg_we && reg_addr == ADDR_FLAG;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= SENSE_LOW;
      en_ext_q <= 1'b0;
      en_grp_q <= '0;
    end else begin
      if (mode_wr) mode_q <= sense_e'(reg_wdata[1:0]);
      if (reg_we && reg_addr == ADDR_EN) begin
        en_ext_q <= reg_wdata[BIT_EXT];
        en_grp_q <= {reg_wdata[BIT_G1], reg_wdata[BIT_G0]};
      end
    end
  end

  irq_sampler #(.W(NPAD)) u_samp (
    .clk(clk), .rst_n(rst_n), .pad({pc_pad, ext_pad}),
    .cur(s_cur), .prev(s_prev), .hist_ok(hist_ok)
  );

  ext_sense u_ext (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .cur(s_cur[0]), .prev(s_prev[0]),
    .hist_ok(hist_ok), .ack(ext_ack), .w1c(flag_wr && reg_wdata[BIT_EXT]),
    .mode_wr(mode_wr), .evt(ext_evt), .flag(ext_flag), .pend(ext_pend)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    pc_detect #(.PINS(PC_PINS)) u_pc (
      .clk(clk), .rst_n(rst_n),
      .cur(s_cur[1+g*PC_PINS +: PC_PINS]),
      .prev(s_prev[1+g*PC_PINS +: PC_PINS]),
      .mask(pc_mask[g*PC_PINS +: PC_PINS]),
      .hist_ok(hist_ok), .ack(pc_ack[g]),
      .w1c(flag_wr && reg_wdata[BIT_G0+g]),
      .evt(grp_evt[g]), .flag(grp_flag[g])
    );
    assign pc_req[g] = gie & en_grp_q[g] & grp_flag[g];
  end

  assign ext_req = gie & en_ext_q & ext_pend;

  always_comb begin
    irq_valid = ext_req | (|pc_req);
    if (ext_req)        irq_id = 2'd0;
    else if (pc_req[0]) irq_id = 2'd1;
    else if (pc_req[1]) irq_id = 2'd2;
    else                irq_id = 2'd0;
  end

  always_comb begin
    reg_rdata = 8'h00;
    case (reg_addr)
      ADDR_MODE: reg_rdata[1:0] = mode_q;
      ADDR_EN: begin
        reg_rdata[BIT_EXT] = en_ext_q;
        reg_rdata[BIT_G1]  = en_grp_q[1];
        reg_rdata[BIT_G0]  = en_grp_q[0];
      end
      ADDR_FLAG: begin
        reg_rdata[BIT_EXT] = ext_flag;
        reg_rdata[BIT_G1]  = grp_flag[1];
        reg_rdata[BIT_G0]  = grp_flag[0];
      end
      default: reg_rdata = 8'h00;
    endcase
  end

  a_r5_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req || pc_req != 2'b00) |-> gie);
  a_r9_ext_first: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |-> (irq_valid && irq_id == 2'd0));
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_EN) |-> (reg_rdata[7] == 1'b0 && reg_rdata[3:0] == 4'h0));
  a_r8_event_beats_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_evt && ext_ack && !mode_wr) |=> ext_flag);
endmodule

// File: tb/ext_irq_unit_tb_top.sv
`timescale 1ns/1ps
module ext_irq_unit_tb_top;
  localparam int P = 4;
  logic clk = 0, rst_n = 0;
  logic [1:0] reg_addr = 0;
  logic reg_we = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic gie = 0, ext_pad = 0, ext_ack = 0;
  logic [2*P-1:0] pc_pad = 0, pc_mask = 0;
  logic [1:0] pc_ack = 0, pc_req, irq_id;
  logic ext_req, irq_valid;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ext_irq_unit #(.PC_PINS(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gie(gie), .ext_pad(ext_pad),
    .pc_pad(pc_pad), .pc_mask(pc_mask), .ext_ack(ext_ack), .pc_ack(pc_ack),
    .ext_req(ext_req), .pc_req(pc_req), .irq_valid(irq_valid), .irq_id(irq_id)
  );

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic bit exp_edge(int m, bit from, bit to);
    if (m == 1) return from != to;
    if (m == 2) return from && !to;
    if (m == 3) return !from && to;
    return 0;
  endfunction

  initial begin
    logic [7:0] d;
    cyc(3); rst_n = 1; cyc(5);
    // R1 reset state
    rd(0, d); chk(d, 0, "R1 mode reset");
    rd(1, d); chk(d, 0, "R1 enable reset");
    rd(2, d); chk(d, 0, "R1 flags reset");
    chk({ext_req, pc_req, irq_valid}, 0, "R1 requests idle");
    // R2 reserved bits
    wr(1, 8'hFF); rd(1, d); chk(d, 8'h70, "R2 enable readback");
    wr(0, 8'hFF); rd(0, d); chk(d, 8'h03, "R2 mode readback");
    gie = 1;
    // R3 sweep modes x transitions
    for (int m = 1; m < 4; m++) begin
      for (int t = 0; t < 2; t++) begin
        ext_pad = t[0]; cyc(5);
        wr(0, 8'(m)); wr(2, 8'h40); cyc(2);
        ext_pad = !t[0]; cyc(5);
        rd(2, d);
        chk(d[6], exp_edge(m, t[0], !t[0]), $sformatf("R3 mode %0d from %0d flag", m, t));
        chk(ext_req, exp_edge(m, t[0], !t[0]), "R3 ext_req");
      end
    end
    // R10 mode write clears pending flag
    wr(0, 8'h01); rd(2, d); chk(d[6], 0, "R10 mode write clears flag");
    // R4 low level not latched
    ext_pad = 1; cyc(4); wr(0, 8'h00); cyc(2);
    chk(ext_req, 0, "R4 high pad no request");
    ext_pad = 0; cyc(4); chk(ext_req, 1, "R4 low pad requests");
    ext_pad = 1; cyc(4); chk(ext_req, 0, "R4 request drops, not latched");
    // R6 two-cycle pulse in rising mode
    ext_pad = 0; cyc(4); wr(0, 8'h03); cyc(2);
    ext_pad = 1; cyc(2); ext_pad = 0; cyc(5);
    rd(2, d); chk(d[6], 1, "R6 short pulse caught");
    // R8 acknowledge clears
    ext_ack = 1; cyc(1); ext_ack = 0; cyc(1);
    rd(2, d); chk(d[6], 0, "R8 ack clears ext flag");
    // R8 ack in the event cycle keeps flag
    ext_pad = 1; cyc(2); ext_ack = 1; cyc(1); ext_ack = 0; cyc(1);
    rd(2, d); chk(d[6], 1, "R8 event beats ack");
    // R5 gating
    gie = 0; #1; chk(ext_req, 0, "R5 gie low blocks");
    gie = 1; wr(1, 8'h30); chk(ext_req, 0, "R5 enable low blocks");
    wr(1, 8'h70); chk(ext_req, 1, "R5 both set passes");
    wr(2, 8'h40); rd(2, d); chk(d[6], 0, "R8 write one clears");
    // R7 group sweep
    for (int g = 0; g < 2; g++) begin
      for (int p = 0; p < P; p++) begin
        for (int mb = 0; mb < 2; mb++) begin
          pc_mask = '0; pc_mask[g*P+p] = mb[0];
          wr(2, 8'h30); cyc(1);
          pc_pad[g*P+p] = !pc_pad[g*P+p]; cyc(5);
          rd(2, d);
          chk(d[4+g], mb, $sformatf("R7 group %0d pin %0d mask %0d", g, p, mb));
          chk(pc_req[g], mb, "R7 pc_req");
        end
      end
    end
    // R9 priority: both groups pending, then ext
    chk({irq_valid, irq_id}, {1'b1, 2'd2}, "R9 group 1 only");
    pc_mask = '1; pc_pad[0] = !pc_pad[0]; cyc(5);
    chk({irq_valid, irq_id}, {1'b1, 2'd1}, "R9 group 0 over group 1");
    ext_pad = 0; wr(0, 8'h00); cyc(4);
    chk({irq_valid, irq_id}, {1'b1, 2'd0}, "R9 ext first");
    pc_ack = 2'b11; cyc(1); pc_ack = 0; ext_pad = 1; cyc(4);
    chk({irq_valid, pc_req, ext_req}, 0, "R8 R9 all cleared");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule